// File: doc/BRIEF.md
# Command-Driven 2D Drawing Engine

This block draws into a 320x240 framebuffer whose pixels are 4-bit palette indices. Software fills four 16-bit argument slots, then writes a control byte with a colour index and a command code. The engine then emits one framebuffer write per cycle on a pixel port until the shape is done. It supports four shapes: a single point, a filled rectangle, a straight line, and an 8x8 sprite copied from an internal sprite store.

While a command runs, the command field of the control byte reads back the running code. When the command ends, that field returns to zero and a one-cycle finished pulse fires. A command code the engine does not handle, or any argument outside its legal range, draws nothing. Such a command clears the command field and fires a separate error pulse instead.

Sprite rows are loaded through their own write port. Each row is one 32-bit word holding eight 4-bit pixels. During a sprite copy, a 16-bit transparency mask suppresses chosen colour indices, and pixels that land beyond the screen edge are clipped.

Top module: `gfx_engine`

## Requirements
- R1: After reset, ctrl_q is 0, busy is 0, and px_we, irq_done and irq_bad are all 0.
- R2: The control byte carries the colour in bits 7:4 and the command code in bits 3:0. The codes are 0 sprite copy, 1 line, 2 filled rectangle and 4 single point. A valid command raises busy in the cycle after the control write, and its first pixel appears in that same cycle. px_we is never high while the engine is idle.
- R3: While a command runs, ctrl_q holds the written control byte unchanged. After the command ends, bits 3:0 read 0 and bits 7:4 keep the colour.
- R4: irq_done is high for exactly one cycle: the cycle after the last pixel slot. In that cycle busy is 0 and ctrl_q[3:0] is 0.
- R5: A single-point command (arguments X in slot 0, Y in slot 1) writes exactly one pixel at (X,Y) in the control colour, and is busy for one cycle.
- R6: A filled rectangle (X1, Y1, X2, Y2 in slots 0 to 3) writes every pixel between the two corners inclusive. Corners are normalised, so either order gives the same result. Pixels come out row by row from the top, each row from left to right, one per cycle.
- R7: A line (same slot layout as R6) follows integer Bresenham stepping and writes both end points. The error term starts at dx-dy. On each step x moves when 2*err >= -dy, and y moves when 2*err <= dx. The command takes one cycle per pixel.
- R8: A sprite copy (sprite index in slot 0, X in slot 1, Y in slot 2) always spends 64 cycles, scanning rows 0..7 and, within each row, columns 0..7. The pixel at (row,col) is bits 4*col+3:4*col of sprite row word index*8+row. It is written at (X+col, Y+row) with that nibble as its colour.
- R9: During a sprite copy, a pixel is not written if its nibble's bit in the transparency mask is 1, or if it lands at x >= 320 or y >= 240. No pixel is ever emitted off screen.
- R10: A control write is invalid if its code is 3 or above 4, or if an argument is out of range (X > 319, Y > 239, sprite index > 511). An invalid write emits no pixel and leaves busy at 0. It sets ctrl_q to {colour, 0} and pulses irq_bad for one cycle, in the cycle after the write.
- R11: While busy, writes to the argument slots, the control byte and the mask are ignored.
- R12: reg_sel picks the target of a register write: 0 to 3 are the argument slots, 4 is the control byte (low 8 bits of reg_wdata), and 5 is the transparency mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (R12) |
| reg_wdata | input | 16 | Register write data |
| spr_we | input | 1 | Sprite row write strobe |
| spr_waddr | input | 12 | Sprite row address, index*8+row |
| spr_wdata | input | 32 | Eight 4-bit pixels, column 0 in bits 3:0 |
| ctrl_q | output | 8 | Control byte readback |
| busy | output | 1 | Command in progress |
| px_we | output | 1 | Framebuffer pixel write strobe |
| px_x | output | 9 | Pixel column |
| px_y | output | 8 | Pixel row |
| px_color | output | 4 | Pixel palette index |
| irq_done | output | 1 | Command-finished pulse |
| irq_bad | output | 1 | Invalid-command pulse |

## Verification
Each shape is tried with directed and random inputs, and the whole ordered pixel stream is compared with a bench model.

- Fills use both corner orders and degenerate one-row and one-column boxes. These show whether normalisation and the row wrap are right.
- Lines cover flat, steep, reversed and zero-length cases. These separate errors in the octant handling, the step tests and the end-point test.
- Sprite copies at the screen corners, with masks both empty and non-empty, separate clipping from transparency.
- Bad codes, edge-value arguments and writes made while busy show that rejected or ignored writes leave no trace.

// File: rtl/gfx_engine.sv
module gfx_engine #(
  parameter int SCR_W = 320,
  parameter int SCR_H = 240,
  parameter int SPR_NUM = 512,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H),
  localparam int SW = $clog2(SPR_NUM),
  localparam int AW = SW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  input  logic          spr_we,
  input  logic [AW-1:0] spr_waddr,
  input  logic [31:0]   spr_wdata,
  output logic [7:0]    ctrl_q,
  output logic          busy,
  output logic          px_we,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic [3:0]    px_color,
  output logic          irq_done,
  output logic          irq_bad
);
  localparam int CW = XW + 1;
  localparam int RW = YW + 1;
  localparam int EW = CW + 2;
  localparam logic [15:0] W16 = 16'(SCR_W);
  localparam logic [15:0] H16 = 16'(SCR_H);
  localparam logic [15:0] N16 = 16'(SPR_NUM);

  typedef enum logic [2:0] {S_IDLE, S_PIX, S_FILL, S_LINE, S_BLIT} st_t;

  st_t st;
  logic [15:0] a0, a1, a2, a3, tmask;
  logic [31:0] spr_mem [SPR_NUM*8];
  logic [CW-1:0] cx;
  logic [RW-1:0] cy;
  logic signed [EW-1:0] err;
  logic [5:0] cnt;

  always_ff @(posedge clk)
    if (spr_we) spr_mem[spr_waddr] <= spr_wdata;

  assign busy = (st != S_IDLE);

  wire idle_wr = reg_we && (st == S_IDLE);
  wire start   = idle_wr && (reg_sel == 3'd4);
  wire [3:0] code = reg_wdata[3:0];

  wire ok_pix  = (a0 < W16) && (a1 < H16);
  wire ok_two  = ok_pix && (a2 < W16) && (a3 < H16);
  wire ok_blit = (a0 < N16) && (a1 < W16) && (a2 < H16);
  logic cmd_ok;
  always_comb
    case (code)
      4'd0:    cmd_ok = ok_blit;
      4'd1,
      4'd2:    cmd_ok = ok_two;
      4'd4:    cmd_ok = ok_pix;
      default: cmd_ok = 1'b0;
    endcase

  wire [CW-1:0] x1 = a0[CW-1:0];
  wire [RW-1:0] y1 = a1[RW-1:0];
  wire [CW-1:0] x2 = a2[CW-1:0];
  wire [RW-1:0] y2 = a3[RW-1:0];
  wire lsx = (x2 >= x1);
  wire lsy = (y2 >= y1);
  wire [CW-1:0] ldx = lsx ? x2 - x1 : x1 - x2;
  wire [RW-1:0] ldy = lsy ? y2 - y1 : y1 - y2;
  wire signed [EW-1:0] sdx = $signed(EW'(ldx));
  wire signed [EW-1:0] sdy = $signed(EW'(ldy));
  wire signed [EW-1:0] e2 = err <<< 1;
  wire step_x = (e2 >= -sdy);
  wire step_y = (e2 <= sdx);
  wire signed [EW-1:0] err_n = err - (step_x ? sdy : '0) + (step_y ? sdx : '0);

  wire [CW-1:0] fxl = lsx ? x1 : x2;
  wire [CW-1:0] fxr = lsx ? x2 : x1;
  wire [RW-1:0] fyt = lsy ? y1 : y2;
  wire [RW-1:0] fyb = lsy ? y2 : y1;

  wire [2:0] brow = cnt[5:3];
  wire [2:0] bcol = cnt[2:0];
  wire [31:0] rowdata = spr_mem[{a0[SW-1:0], brow}];
  wire [3:0] nib = rowdata[{bcol, 2'b00} +: 4];
  wire [CW-1:0] tx = a1[CW-1:0] + CW'(bcol);
  wire [RW-1:0] ty = a2[RW-1:0] + RW'(brow);
  wire b_vis = !tmask[nib] && (tx < CW'(SCR_W)) && (ty < RW'(SCR_H));

  logic last;
  always_comb begin
    px_we = 1'b0;
    px_x = cx[XW-1:0];
    px_y = cy[YW-1:0];
    px_color = ctrl_q[7:4];
    last = 1'b0;
    case (st)
      S_PIX:  begin px_we = 1'b1; last = 1'b1; end
      S_FILL: begin px_we = 1'b1; last = (cx == fxr) && (cy == fyb); end
      S_LINE: begin px_we = 1'b1; last = (cx == x2) && (cy == y2); end
      S_BLIT: begin
        px_we = b_vis;
        px_x = tx[XW-1:0];
        px_y = ty[YW-1:0];
        px_color = nib;
        last = (cnt == 6'd63);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      {a0, a1, a2, a3, tmask} <= '0;
      ctrl_q <= '0;
      cx <= '0;
      cy <= '0;
      err <= '0;
      cnt <= '0;
      irq_done <= 1'b0;
      irq_bad <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_bad <= 1'b0;
      if (idle_wr)
        case (reg_sel)
          3'd0: a0 <= reg_wdata;
          3'd1: a1 <= reg_wdata;
          3'd2: a2 <= reg_wdata;
          3'd3: a3 <= reg_wdata;
          3'd5: tmask <= reg_wdata;
          default: ;
        endcase
      if (start) begin
        if (cmd_ok) begin
          ctrl_q <= reg_wdata[7:0];
          cnt <= '0;
          case (code)
            4'd0: st <= S_BLIT;
            4'd1: begin st <= S_LINE; cx <= x1; cy <= y1; err <= sdx - sdy; end
            4'd2: begin st <= S_FILL; cx <= fxl; cy <= fyt; end
            default: begin st <= S_PIX; cx <= x1; cy <= y1; end
          endcase
        end else begin
          ctrl_q <= {reg_wdata[7:4], 4'h0};
          irq_bad <= 1'b1;
        end
      end else if (busy) begin
        if (last) begin
          st <= S_IDLE;
          ctrl_q[3:0] <= 4'h0;
          irq_done <= 1'b1;
        end else
          case (st)
            S_FILL:
              if (cx == fxr) begin cx <= fxl; cy <= cy + 1'b1; end
              else cx <= cx + 1'b1;
            S_LINE: begin
              if (step_x) cx <= lsx ? cx + 1'b1 : cx - 1'b1;
              if (step_y) cy <= lsy ? cy + 1'b1 : cy - 1'b1;
              err <= err_n;
            end
            S_BLIT: cnt <= cnt + 1'b1;
            default: ;
          endcase
      end
    end
endmodule

module gfx_engine_chk #(
  parameter int SCR_W = 320,
  parameter int SCR_H = 240,
  parameter int XW = 9,
  parameter int YW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [7:0]    ctrl_q,
  input logic          px_we,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic          irq_done,
  input logic          irq_bad
);
  // R9
  on_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |-> (int'(px_x) < SCR_W) && (int'(px_y) < SCR_H));
  // R2
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |-> busy);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !busy && (ctrl_q[3:0] == 4'h0) && !irq_bad);
  // R4
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_done);
  // R10
  bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_bad |-> !busy && (ctrl_q[3:0] == 4'h0));
  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_q));
endmodule

bind gfx_engine gfx_engine_chk #(.SCR_W(SCR_W), .SCR_H(SCR_H), .XW(XW), .YW(YW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctrl_q(ctrl_q), .px_we(px_we),
  .px_x(px_x), .px_y(px_y), .irq_done(irq_done), .irq_bad(irq_bad));

// File: tb/gfx_engine_tb.sv
module gfx_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, spr_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [11:0] spr_waddr = '0;
  logic [31:0] spr_wdata = '0;
  logic [7:0] ctrl_q;
  logic busy, px_we, irq_done, irq_bad;
  logic [8:0] px_x;
  logic [7:0] px_y;
  logic [3:0] px_color;

  always #10 clk = ~clk;

  gfx_engine dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .spr_we(spr_we), .spr_waddr(spr_waddr), .spr_wdata(spr_wdata),
    .ctrl_q(ctrl_q), .busy(busy), .px_we(px_we), .px_x(px_x), .px_y(px_y),
    .px_color(px_color), .irq_done(irq_done), .irq_bad(irq_bad));

  int n_chk = 0, n_bad = 0;
  int sh [4];
  int shmask = 0;
  logic [31:0] smem [4096];
  int ex [4096], ey [4096], ec [4096];
  int en = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int x, input int y, input int c);
    ex[en] = x; ey[en] = y; ec[en] = c; en++;
  endtask

  task automatic set_reg(input int sel, input int data);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = 16'(data);
    @(negedge clk);
    reg_we = 1'b0;
    if (sel < 4) sh[sel] = data;
    if (sel == 5) shmask = data;
  endtask

  task automatic set_args(input int p, input int q, input int r, input int s);
    set_reg(0, p); set_reg(1, q); set_reg(2, r); set_reg(3, s);
  endtask

  task automatic model_fill(input int c);
    int xl, xr, yt, yb;
    xl = sh[0] < sh[2] ? sh[0] : sh[2]; xr = sh[0] < sh[2] ? sh[2] : sh[0];
    yt = sh[1] < sh[3] ? sh[1] : sh[3]; yb = sh[1] < sh[3] ? sh[3] : sh[1];
    en = 0;
    for (int y = yt; y <= yb; y++)
      for (int x = xl; x <= xr; x++) push(x, y, c);
  endtask

  task automatic model_line(input int c);
    int x, y, dx, dy, sx, sy, e, e2;
    x = sh[0]; y = sh[1];
    dx = sh[2] > x ? sh[2] - x : x - sh[2];
    dy = sh[3] > y ? y - sh[3] : sh[3] - y;
    sx = sh[2] >= x ? 1 : -1; sy = sh[3] >= y ? 1 : -1;
    e = dx + dy; en = 0;
    forever begin
      push(x, y, c);
      if (x == sh[2] && y == sh[3]) break;
      e2 = 2 * e;
      if (e2 >= dy) begin e += dy; x += sx; end
      if (e2 <= dx) begin e += dx; y += sy; end
    end
  endtask

  task automatic model_blit();
    en = 0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        int nb;
        nb = int'(smem[sh[0] * 8 + r][4 * c +: 4]);
        if (!shmask[nb] && sh[1] + c < 320 && sh[2] + r < 240) push(sh[1] + c, sh[2] + r, nb);
      end
  endtask

  task automatic run_cmd(input int ctl, input int cyc_exp, input bit bad_exp, input bit intrude, input string req);
    int gn, cyc, k;
    bit done, bad, seq_ok;
    int gx [4096], gy [4096], gc [4096];
    gn = 0; cyc = 0; k = 0; done = 0; bad = 0; seq_ok = 1;
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 16'(ctl);
    @(negedge clk);
    reg_we = 1'b0;
    while (k < 5000) begin
      if (px_we) begin
        if (gn < 4096) begin gx[gn] = int'(px_x); gy[gn] = int'(px_y); gc[gn] = int'(px_color); end
        gn++;
      end
      if (busy) cyc++;
      if (k == 0 && !bad_exp) chk(busy && ctrl_q == 8'(ctl), "R3", "ctrl while busy", int'(ctrl_q), ctl);
      if (irq_done) done = 1;
      if (irq_bad) bad = 1;
      if (done || bad) break;
      reg_we = 1'b0;
      if (intrude && k == 0) begin reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 16'd7; end
      if (intrude && k == 1) begin reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 16'h34; end
      @(negedge clk);
      k++;
    end
    reg_we = 1'b0;
    chk(bad == bad_exp && done == !bad_exp, req, "completion irq kind (bad)", int'(bad), int'(bad_exp));
    chk(cyc == cyc_exp, req, "busy cycles", cyc, cyc_exp);
    chk(gn == en, req, "pixel count", gn, en);
    for (int i = 0; i < gn && i < en; i++)
      if (gx[i] != ex[i] || gy[i] != ey[i] || gc[i] != ec[i]) begin
        if (seq_ok) $display("FAIL %s pixel %0d: actual (%0d,%0d,c%0d) expected (%0d,%0d,c%0d)",
                             req, i, gx[i], gy[i], gc[i], ex[i], ey[i], ec[i]);
        seq_ok = 0;
      end
    n_chk++; if (!seq_ok) n_bad++;
    chk(ctrl_q == 8'(ctl & 8'hF0), "R3", "ctrl after end", int'(ctrl_q), ctl & 8'hF0);
    @(negedge clk);
    chk(!irq_done && !irq_bad && !busy, "R4", "pulse width one cycle", int'({irq_done, irq_bad}), 0);
  endtask

  task automatic do_fill(input int c, input bit intr);
    model_fill(c); run_cmd(c * 16 + 2, en, 0, intr, "R6");
  endtask
  task automatic do_line(input int c);
    model_line(c); run_cmd(c * 16 + 1, en, 0, 0, "R7");
  endtask
  task automatic do_pix(input int c);
    en = 0; push(sh[0], sh[1], c); run_cmd(c * 16 + 4, 1, 0, 0, "R5");
  endtask
  task automatic do_blit(input string req);
    model_blit(); run_cmd(16 * 9, 64, 0, 0, req);
  endtask
  task automatic do_bad(input int ctl);
    en = 0; run_cmd(ctl, 0, 1, 0, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    foreach (sh[i]) sh[i] = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(ctrl_q == 0 && !busy && !px_we && !irq_done && !irq_bad, "R1", "reset state", int'(ctrl_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_q == 0 && !busy && !px_we, "R1", "idle after reset", int'(busy), 0);
    for (int i = 0; i < 4096; i++) begin
      smem[i] = $urandom;
      spr_we = 1'b1; spr_waddr = 12'(i); spr_wdata = smem[i];
      @(negedge clk);
    end
    spr_we = 1'b0;

    // R5 R12: single point
    set_args(319, 239, 0, 0); do_pix(5);
    set_args(0, 0, 0, 0); do_pix(15);
    // R6: corner orders and degenerate boxes
    set_args(10, 20, 14, 23); do_fill(3, 0);
    set_args(14, 23, 10, 20); do_fill(6, 0);
    set_args(300, 5, 300, 9); do_fill(1, 0);
    set_args(2, 239, 9, 239); do_fill(2, 0);
    // R7: flat, steep, reversed, single point
    set_args(0, 0, 319, 0); do_line(4);
    set_args(5, 200, 9, 0); do_line(7);
    set_args(300, 100, 10, 130); do_line(8);
    set_args(50, 50, 50, 50); do_line(9);
    // R8 R9: plain copy, clipped copy, transparency
    set_reg(5, 0); set_args(511, 100, 100, 0); do_blit("R8");
    set_args(3, 315, 236, 0); do_blit("R9");
    set_reg(5, 16'h8421); set_args(77, 0, 0, 0); do_blit("R9");
    set_reg(5, 16'hFFFF); set_args(12, 40, 40, 0); do_blit("R9");
    set_reg(5, 0);
    // R10: bad codes and out-of-range args
    do_bad(16'h53); do_bad(16'hA7); do_bad(16'h1F);
    set_args(320, 0, 0, 0); do_bad(16'h24);
    set_args(0, 240, 0, 0); do_bad(16'h34);
    set_args(0, 0, 320, 5); do_bad(16'h22);
    set_args(0, 0, 5, 240); do_bad(16'h21);
    set_args(512, 0, 0, 0); do_bad(16'h60);
    // R11: writes while busy are ignored
    set_args(30, 40, 33, 41); do_fill(2, 1);
    en = 0; push(30, 40, 11); run_cmd(16 * 11 + 4, 1, 0, 0, "R11");

    for (int n = 0; n < 60; n++) begin
      int kind, c;
      kind = $urandom_range(0, 3); c = $urandom_range(0, 15);
      if (kind == 0) begin
        set_args($urandom_range(0, 319), $urandom_range(0, 239), 0, 0); do_pix(c);
      end else if (kind == 1) begin
        int x, y;
        x = $urandom_range(0, 300); y = $urandom_range(0, 220);
        if ($urandom_range(0, 1) == 1) set_args(x, y, x + $urandom_range(0, 15), y + $urandom_range(0, 15));
        else set_args(x + $urandom_range(0, 15), y + $urandom_range(0, 15), x, y);
        do_fill(c, 0);
      end else if (kind == 2) begin
        set_args($urandom_range(0, 319), $urandom_range(0, 239), $urandom_range(0, 319), $urandom_range(0, 239));
        do_line(c);
      end else begin
        set_reg(5, ($urandom_range(0, 1) == 1) ? $urandom_range(0, 65535) : 0);
        set_args($urandom_range(0, 511), $urandom_range(0, 319), $urandom_range(0, 239), 0);
        do_blit("R8");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule